// File: doc/BRIEF.md
# Remote endpoint match table

This block keeps a fixed number of slots, each holding one matched remote writer endpoint: a three-word participant prefix, a 32-bit entity identifier and one unicast locator word. Discovery frames come in one word at a time from an input FIFO, using data, empty, read-strobe and last-word signals. Each frame does one of three things: it matches an endpoint, which adds the endpoint or refreshes its locator; it unmatches a single endpoint; or it unmatches a whole participant, which removes every endpoint whose prefix matches.

Whenever a slot is freed, the block sends a remove command to a downstream cache over a start/ack/done handshake. The command data word is the number of the freed slot. A combinational read port lets a checker or neighbour look at any slot. An idle output shows when no frame is being handled and no table write is pending.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for and takes the opcode word.
- `ST_RECV`: collects the remaining words of a known frame.
- `ST_SKIP`: drains an unknown or malformed frame up to its last word.
- `ST_EXEC`: applies a match or an endpoint unmatch.
- `ST_SCAN`: walks the slots for a participant unmatch.
- `ST_CMD`: holds start until ack arrives.
- `ST_WAIT_DONE`: waits for done.

The transitions are:
- IDLE→RECV on a known opcode.
- IDLE→SKIP on an unknown opcode without the last flag.
- RECV→EXEC at the expected final word when it carries the last flag.
- RECV→SKIP when that word lacks the flag.
- RECV→IDLE on an early last flag.
- SKIP→IDLE on the last word.
- EXEC→IDLE when a match is applied, when an endpoint unmatch misses, or when a match is dropped because the table is full.
- EXEC→CMD on an endpoint unmatch hit.
- EXEC→SCAN on a participant unmatch.
- SCAN→CMD on a prefix hit.
- SCAN→IDLE after the top slot.
- CMD→WAIT_DONE on ack.
- WAIT_DONE→SCAN when a participant scan still has slots left.
- WAIT_DONE→IDLE otherwise.

Top module: `endpoint_match_table`

## Requirements
- R1: After reset, every slot reads invalid, `idle` is high, and `cmd_start` is low.
- R2: Frame layout:
  - Word 0 is the opcode: 1 = endpoint match, 2 = endpoint unmatch, 3 = participant unmatch.
  - Three prefix words follow. The first of them appears in the most significant word of `rd_prefix`.
  - Next comes the entity word, which is absent for opcode 3.
  - Last comes the locator word, present only for opcode 1.
  - The final word of a frame carries `in_last`.
- R3: A match whose prefix and entity are both absent from the table is written, valid, into the lowest-numbered free slot. That slot is visible on the read port in the same cycle `rd_slot` selects it.
- R4: With every slot valid, a match for a new endpoint leaves the whole table unchanged and issues no command.
- R5: A match whose prefix and entity both equal a valid slot's replaces only that slot's locator and issues no command.
- R6: An endpoint unmatch that hits clears the slot and issues one command with opcode 1 and data equal to the slot index. An unmatch that misses changes nothing and issues nothing.
- R7: A participant unmatch clears every valid slot with that prefix and issues one remove command per cleared slot, in ascending slot order.
- R8: A frame with an unknown opcode is read through its last-flagged word with no effect, and the frame after it is processed normally.
- R9: `in_rd` is never high while `in_empty` is high.
- R10: `cmd_start` stays high, with `cmd_opcode` and `cmd_data` stable, until `cmd_ack` is seen. No new command starts before `cmd_done`.
- R11: `idle` is high only when no frame is in progress and no command is outstanding. The table does not change while `idle` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | FIFO data word |
| in_empty | input | 1 | FIFO empty flag |
| in_last | input | 1 | Marks the final word of a frame |
| in_rd | output | 1 | FIFO read strobe |
| cmd_start | output | 1 | Command request |
| cmd_opcode | output | 2 | Command opcode (1 = remove) |
| cmd_data | output | 32 | Command data, the slot index |
| cmd_ack | input | 1 | Command accepted |
| cmd_done | input | 1 | Command finished |
| rd_slot | input | SLOT_W | Slot selected for reading |
| rd_valid | output | 1 | Selected slot is occupied |
| rd_prefix | output | 96 | Selected slot's participant prefix |
| rd_entity | output | 32 | Selected slot's entity identifier |
| rd_locator | output | 32 | Selected slot's locator |
| idle | output | 1 | No frame or command in progress |

## Verification
The bench builds the block with its default of three slots. Three slots is small enough that two plain matches leave one slot free and a third match fills the table. That puts the full-table drop, reuse of a freed middle slot and a participant unmatch clearing two slots at once within a short frame sequence. A downstream responder that acks one cycle after start and signals done one cycle after that gives the command path real handshake gaps between consecutive removals.

// File: rtl/emt_pkg.sv
package emt_pkg;
    localparam int WORD_W    = 32;
    localparam int PFX_WORDS = 3;
    localparam int PFX_W     = PFX_WORDS * WORD_W;

    typedef logic [PFX_W-1:0] prefix_t;

    typedef struct packed {
        prefix_t             prefix;
        logic [WORD_W-1:0]   entity;
        logic [WORD_W-1:0]   locator;
    } ep_rec_t;

    typedef enum logic [1:0] {
        FOP_NONE     = 2'd0,
        FOP_MATCH    = 2'd1,
        FOP_UNMATCH  = 2'd2,
        FOP_PART_DEL = 2'd3
    } frame_op_t;

    localparam logic [1:0] CMD_REMOVE = 2'd1;

    // index of the final word of each known frame type
    function automatic logic [2:0] final_word(frame_op_t op);
        case (op)
            FOP_MATCH:    final_word = 3'd5;
            FOP_UNMATCH:  final_word = 3'd4;
            FOP_PART_DEL: final_word = 3'd3;
            default:      final_word = 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/emt_store.sv
module emt_store
    import emt_pkg::*;
#(
    parameter int SLOTS  = 3,
    parameter int SLOT_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SLOT_W-1:0]   wr_idx,
    input  ep_rec_t             wr_rec,
    input  logic                loc_en,
    input  logic [SLOT_W-1:0]   loc_idx,
    input  logic [WORD_W-1:0]   loc_val,
    input  logic                clr_en,
    input  logic [SLOT_W-1:0]   clr_idx,
    output logic [SLOTS-1:0]    valid,
    output ep_rec_t [SLOTS-1:0] recs
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[g] <= 1'b0;
                recs[g]  <= '0;
            end else if (clr_en && clr_idx == SLOT_W'(g)) begin
                valid[g] <= 1'b0;
                recs[g]  <= '0;
            end else if (wr_en && wr_idx == SLOT_W'(g)) begin
                valid[g] <= 1'b1;
                recs[g]  <= wr_rec;
            end else if (loc_en && loc_idx == SLOT_W'(g)) begin
                recs[g].locator <= loc_val;
            end
        end
    end
endmodule

// File: rtl/emt_lookup.sv
module emt_lookup
    import emt_pkg::*;
#(
    parameter int SLOTS  = 3,
    parameter int SLOT_W = 2
) (
    input  logic [SLOTS-1:0]    valid,
    input  ep_rec_t [SLOTS-1:0] recs,
    input  prefix_t             key_prefix,
    input  logic [WORD_W-1:0]   key_entity,
    output logic [SLOTS-1:0]    pfx_hit,
    output logic                ep_hit,
    output logic [SLOT_W-1:0]   ep_idx,
    output logic                free_any,
    output logic [SLOT_W-1:0]   free_idx
);
    logic [SLOTS-1:0] full_hit;

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign pfx_hit[g]  = valid[g] && (recs[g].prefix == key_prefix);
        assign full_hit[g] = pfx_hit[g] && (recs[g].entity == key_entity);
    end

    // downward walk so the lowest index wins
    always_comb begin
        ep_hit   = 1'b0;
        ep_idx   = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (full_hit[i]) begin
                ep_hit = 1'b1;
                ep_idx = SLOT_W'(i);
            end
            if (!valid[i]) begin
                free_any = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/endpoint_match_table.sv
module endpoint_match_table
    import emt_pkg::*;
#(
    parameter int SLOTS  = 3,
    parameter int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         in_data,
    input  logic                in_empty,
    input  logic                in_last,
    output logic                in_rd,
    output logic                cmd_start,
    output logic [1:0]          cmd_opcode,
    output logic [31:0]         cmd_data,
    input  logic                cmd_ack,
    input  logic                cmd_done,
    input  logic [SLOT_W-1:0]   rd_slot,
    output logic                rd_valid,
    output logic [95:0]         rd_prefix,
    output logic [31:0]         rd_entity,
    output logic [31:0]         rd_locator,
    output logic                idle
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_RECV, ST_SKIP, ST_EXEC, ST_SCAN, ST_CMD, ST_WAIT_DONE
    } state_t;

    state_t              st_q, st_d;
    frame_op_t           op_q;
    logic [2:0]          cnt_q;
    prefix_t             key_pfx_q;
    logic [WORD_W-1:0]   key_ent_q;
    logic [WORD_W-1:0]   key_loc_q;
    logic [SLOT_W-1:0]   scan_q;
    logic [SLOT_W-1:0]   cmd_idx_q;

    logic [SLOTS-1:0]    slot_valid;
    ep_rec_t [SLOTS-1:0] slot_recs;
    logic [SLOTS-1:0]    pfx_hit;
    logic                ep_hit, free_any;
    logic [SLOT_W-1:0]   ep_idx, free_idx;

    logic                rd_fire;
    frame_op_t           in_op;
    logic                in_known;
    logic                scan_last;
    logic                wr_en, loc_en, clr_en;
    logic [SLOT_W-1:0]   clr_idx;

    assign rd_fire   = in_rd;
    assign in_op     = frame_op_t'(in_data[1:0]);
    assign in_known  = (in_data[31:2] == '0) && (in_data[1:0] != 2'd0);
    assign scan_last = (int'(scan_q) == SLOTS - 1);

    emt_store #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (free_idx),
        .wr_rec  ('{prefix: key_pfx_q, entity: key_ent_q, locator: key_loc_q}),
        .loc_en  (loc_en),
        .loc_idx (ep_idx),
        .loc_val (key_loc_q),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .valid   (slot_valid),
        .recs    (slot_recs)
    );

    emt_lookup #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_lookup (
        .valid      (slot_valid),
        .recs       (slot_recs),
        .key_prefix (key_pfx_q),
        .key_entity (key_ent_q),
        .pfx_hit    (pfx_hit),
        .ep_hit     (ep_hit),
        .ep_idx     (ep_idx),
        .free_any   (free_any),
        .free_idx   (free_idx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (!in_empty) begin
                if (in_last)       st_d = ST_IDLE;
                else if (in_known) st_d = ST_RECV;
                else               st_d = ST_SKIP;
            end
            ST_RECV: if (!in_empty) begin
                if (cnt_q == final_word(op_q)) st_d = in_last ? ST_EXEC : ST_SKIP;
                else if (in_last)              st_d = ST_IDLE;
            end
            ST_SKIP: if (!in_empty && in_last) st_d = ST_IDLE;
            ST_EXEC: begin
                unique case (op_q)
                    FOP_UNMATCH:  st_d = ep_hit ? ST_CMD : ST_IDLE;
                    FOP_PART_DEL: st_d = ST_SCAN;
                    default:      st_d = ST_IDLE;
                endcase
            end
            ST_SCAN: begin
                if (pfx_hit[scan_q]) st_d = ST_CMD;
                else if (scan_last)  st_d = ST_IDLE;
            end
            ST_CMD:       if (cmd_ack) st_d = ST_WAIT_DONE;
            ST_WAIT_DONE: if (cmd_done)
                st_d = (op_q == FOP_PART_DEL && !scan_last) ? ST_SCAN : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // table write controls
    always_comb begin
        wr_en   = (st_q == ST_EXEC) && (op_q == FOP_MATCH) && !ep_hit && free_any;
        loc_en  = (st_q == ST_EXEC) && (op_q == FOP_MATCH) && ep_hit;
        clr_en  = ((st_q == ST_EXEC) && (op_q == FOP_UNMATCH) && ep_hit) ||
                  ((st_q == ST_SCAN) && pfx_hit[scan_q]);
        clr_idx = (st_q == ST_SCAN) ? scan_q : ep_idx;
    end

    // frame capture and scan datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= FOP_NONE;
            cnt_q     <= '0;
            key_pfx_q <= '0;
            key_ent_q <= '0;
            key_loc_q <= '0;
            scan_q    <= '0;
            cmd_idx_q <= '0;
        end else begin
            if (st_q == ST_IDLE && rd_fire) begin
                op_q  <= in_known ? in_op : FOP_NONE;
                cnt_q <= 3'd1;
            end else if (st_q == ST_RECV && rd_fire) begin
                cnt_q <= cnt_q + 3'd1;
                if (cnt_q >= 3'd1 && cnt_q <= 3'(PFX_WORDS))
                    key_pfx_q[(PFX_WORDS - int'(cnt_q)) * WORD_W +: WORD_W] <= in_data;
                else if (cnt_q == 3'(PFX_WORDS + 1))
                    key_ent_q <= in_data;
                else
                    key_loc_q <= in_data;
            end
            if (st_q == ST_EXEC) scan_q <= '0;
            else if (st_q == ST_SCAN && !pfx_hit[scan_q] && !scan_last) scan_q <= scan_q + 1'b1;
            else if (st_q == ST_WAIT_DONE && cmd_done && !scan_last) scan_q <= scan_q + 1'b1;
            if (clr_en) cmd_idx_q <= clr_idx;
        end
    end

    // outputs
    always_comb begin
        in_rd      = (st_q == ST_IDLE || st_q == ST_RECV || st_q == ST_SKIP) && !in_empty;
        cmd_start  = (st_q == ST_CMD);
        cmd_opcode = cmd_start ? CMD_REMOVE : 2'd0;
        cmd_data   = 32'(cmd_idx_q);
        idle       = (st_q == ST_IDLE);
        if (int'(rd_slot) < SLOTS) begin
            rd_valid   = slot_valid[rd_slot];
            rd_prefix  = slot_recs[rd_slot].prefix;
            rd_entity  = slot_recs[rd_slot].entity;
            rd_locator = slot_recs[rd_slot].locator;
        end else begin
            rd_valid   = 1'b0;
            rd_prefix  = '0;
            rd_entity  = '0;
            rd_locator = '0;
        end
    end
endmodule

// File: rtl/emt_checker.sv
module emt_checker #(
    parameter int SLOTS = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_rd,
    input logic             in_empty,
    input logic             cmd_start,
    input logic             cmd_ack,
    input logic [1:0]       cmd_opcode,
    input logic [31:0]      cmd_data,
    input logic             idle,
    input logic [SLOTS-1:0] tbl_valid
);
    // R9
    rd_while_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd |-> !in_empty);

    // R10
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !cmd_ack) |=> (cmd_start && $stable(cmd_data) && $stable(cmd_opcode)));

    // R6
    cmd_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> (cmd_opcode == 2'd1 && cmd_data < 32'(SLOTS)));

    // R11
    idle_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !cmd_start);

    // R11
    idle_table_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && $past(idle)) |-> $stable(tbl_valid));

    // R10
    ack_drops_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_ack) |=> !cmd_start);
endmodule

bind endpoint_match_table emt_checker #(.SLOTS(SLOTS)) u_emt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_rd      (in_rd),
    .in_empty   (in_empty),
    .cmd_start  (cmd_start),
    .cmd_ack    (cmd_ack),
    .cmd_opcode (cmd_opcode),
    .cmd_data   (cmd_data),
    .idle       (idle),
    .tbl_valid  (slot_valid)
);

// File: tb/endpoint_match_table_bench.sv
module endpoint_match_table_bench;
    localparam int SLOTS  = 3;
    localparam int SLOT_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [32:0] fifo_mem [0:255];
    int          wptr = 0;
    int          rptr = 0;
    logic [31:0] in_data;
    logic        in_empty, in_last, in_rd;
    logic        cmd_start, cmd_ack, cmd_done;
    logic [1:0]  cmd_opcode;
    logic [31:0] cmd_data;
    logic [SLOT_W-1:0] rd_slot = '0;
    logic        rd_valid, idle;
    logic [95:0] rd_prefix;
    logic [31:0] rd_entity, rd_locator;

    assign in_empty = (rptr == wptr);
    assign in_data  = fifo_mem[rptr % 256][31:0];
    assign in_last  = fifo_mem[rptr % 256][32];

    always @(posedge clk) if (in_rd && !in_empty) rptr <= rptr + 1;

    endpoint_match_table #(.SLOTS(SLOTS)) u_endpoint_match_table (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_empty(in_empty),
        .in_last(in_last), .in_rd(in_rd), .cmd_start(cmd_start),
        .cmd_opcode(cmd_opcode), .cmd_data(cmd_data), .cmd_ack(cmd_ack),
        .cmd_done(cmd_done), .rd_slot(rd_slot), .rd_valid(rd_valid),
        .rd_prefix(rd_prefix), .rd_entity(rd_entity), .rd_locator(rd_locator),
        .idle(idle)
    );

    int tests = 0;
    int fails = 0;
    int rd_empty_viol = 0;
    int exp_q[$];

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // downstream cache responder: ack one cycle after start, done one after ack
    always @(posedge clk) begin
        if (!rst_n) begin
            cmd_ack  <= 1'b0;
            cmd_done <= 1'b0;
        end else begin
            cmd_ack  <= cmd_start && !cmd_ack;
            cmd_done <= cmd_ack;
        end
    end

    // scoreboard monitor
    logic [31:0] held_data;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && in_rd && in_empty) rd_empty_viol++;
            if (rst_n && cmd_start && !cmd_ack) begin
                held_data = cmd_data;
                if (exp_q.size() == 0) begin
                    chk("R4/R5/R6 unexpected remove", {96'd0, cmd_data}, 128'hFFFF_FFFF);
                end else begin
                    chk("R6/R7 remove slot", {96'd0, cmd_data}, {96'd0, 32'(exp_q.pop_front())});
                    chk("R6 remove opcode", {126'd0, cmd_opcode}, 128'd1);
                end
            end else if (rst_n && cmd_start && cmd_ack) begin
                chk("R10 data held to ack", {96'd0, cmd_data}, {96'd0, held_data});
            end
        end
    end

    logic        ev [SLOTS];
    logic [95:0] ep [SLOTS];
    logic [31:0] ee [SLOTS];
    logic [31:0] el [SLOTS];

    task automatic set_exp(input int s, input logic v, input logic [95:0] p,
                           input logic [31:0] e, input logic [31:0] l);
        ev[s] = v; ep[s] = p; ee[s] = e; el[s] = l;
    endtask

    task automatic push_word(input logic [31:0] w, input logic last);
        fifo_mem[wptr % 256] = {last, w};
        wptr = wptr + 1;
    endtask

    task automatic push_pfx(input logic [95:0] p);
        push_word(p[95:64], 1'b0);
        push_word(p[63:32], 1'b0);
    endtask

    task automatic send_match(input logic [95:0] p, input logic [31:0] e, input logic [31:0] l);
        push_word(32'd1, 1'b0); push_pfx(p); push_word(p[31:0], 1'b0);
        push_word(e, 1'b0); push_word(l, 1'b1);
    endtask

    task automatic send_unmatch(input logic [95:0] p, input logic [31:0] e);
        push_word(32'd2, 1'b0); push_pfx(p); push_word(p[31:0], 1'b0);
        push_word(e, 1'b1);
    endtask

    task automatic send_part(input logic [95:0] p);
        push_word(32'd3, 1'b0); push_pfx(p); push_word(p[31:0], 1'b1);
    endtask

    task automatic settle(input string req);
        int n = 0;
        @(negedge clk);
        while (!(idle && in_empty) && n < 1000) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
        chk({req, " R11 idle after frame"}, {127'd0, idle}, 128'd1);
        chk({req, " R6/R7 all removes seen"}, 128'(exp_q.size()), 128'd0);
    endtask

    task automatic check_table(input string req);
        for (int s = 0; s < SLOTS; s++) begin
            rd_slot = SLOT_W'(s);
            #1;
            chk({req, " valid"}, {127'd0, rd_valid}, {127'd0, ev[s]});
            if (ev[s]) begin
                chk({req, " R2 prefix"}, {32'd0, rd_prefix}, {32'd0, ep[s]});
                chk({req, " entity"}, {96'd0, rd_entity}, {96'd0, ee[s]});
                chk({req, " locator"}, {96'd0, rd_locator}, {96'd0, el[s]});
            end
        end
    endtask

    localparam logic [95:0] P0 = 96'hA000_0001_A000_0002_A000_0003;
    localparam logic [95:0] P1 = 96'hB000_0001_B000_0002_B000_0003;

    initial begin
        for (int s = 0; s < SLOTS; s++) set_exp(s, 1'b0, '0, '0, '0);
        repeat (3) @(negedge clk);
        // R1 reset state
        check_table("R1 reset");
        chk("R1 idle", {127'd0, idle}, 128'd1);
        chk("R1 no start", {127'd0, cmd_start}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        send_match(P0, 32'hE0, 32'h100); settle("R3 e0");
        set_exp(0, 1'b1, P0, 32'hE0, 32'h100); check_table("R3 e0 slot0");

        send_match(P0, 32'hE1, 32'h101); settle("R3 e1");
        set_exp(1, 1'b1, P0, 32'hE1, 32'h101); check_table("R3 e1 slot1");

        send_match(P1, 32'hE2, 32'h102); settle("R3 e2");
        set_exp(2, 1'b1, P1, 32'hE2, 32'h102); check_table("R3 e2 slot2");

        send_match(P1, 32'hE3, 32'h103); settle("R4 full");
        check_table("R4 full unchanged");

        exp_q.push_back(2);
        send_unmatch(P1, 32'hE2); settle("R6 unmatch e2");
        set_exp(2, 1'b0, '0, '0, '0); check_table("R6 slot2 cleared");

        send_unmatch(P1, 32'hEE); settle("R6 miss");
        check_table("R6 miss unchanged");

        send_match(P1, 32'hE3, 32'h103); settle("R3 reuse");
        set_exp(2, 1'b1, P1, 32'hE3, 32'h103); check_table("R3 e3 slot2");

        exp_q.push_back(0); exp_q.push_back(1);
        send_part(P0); settle("R7 participant");
        set_exp(0, 1'b0, '0, '0, '0); set_exp(1, 1'b0, '0, '0, '0);
        check_table("R7 two cleared");

        send_match(P1, 32'hE2, 32'h102); settle("R3 low free");
        set_exp(0, 1'b1, P1, 32'hE2, 32'h102); check_table("R3 e2 slot0");

        // R8 unknown opcode frame then a normal match
        push_word(32'h77, 1'b0);
        for (int i = 1; i < 9; i++) push_word(32'd1, 1'b0);
        push_word(32'd3, 1'b1);
        send_match(P0, 32'hE0, 32'h100); settle("R8 unknown");
        set_exp(1, 1'b1, P0, 32'hE0, 32'h100); check_table("R8 next frame ok");

        send_match(P1, 32'hE2, 32'h2222); settle("R5 update");
        set_exp(0, 1'b1, P1, 32'hE2, 32'h2222); check_table("R5 locator only");

        chk("R9 no read while empty", 128'(rd_empty_viol), 128'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog R11 actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule